// File: doc/BRIEF.md
# Programmable Almost-Flag Offset Unit

This unit produces the programmable almost-empty and almost-full flags for an 18-bit-wide FIFO. Both flags are active low. The FIFO's storage and pointers sit outside the unit. The unit takes the FIFO fill level as an input and compares it against two 12-bit offsets, one for the empty side and one for the full side. It also tells the pointer logic when a write or read enable really moves a pointer.

The offsets are programmed through the FIFO's normal data buses while a load strobe is held. If the strobe and the write enable are both active on a write-clock edge, the low 12 bits of the data input go into an offset register. If the strobe and the read enable are both active on a read-clock edge, an offset register is returned on the data output. A sequencer picks the register for each access. The load path and the readback path each have their own sequencer. Each sequencer steps almost-empty, then almost-full, then back again.

A strap is sampled during reset and selects the flag update mode. In synchronous mode, each flag is a register clocked by its own port: almost-full by the write clock, almost-empty by the read clock. In asynchronous mode, each flag follows the fill level through logic only.

Top module: `almost_flag_unit`

## Requirements
- R1: While `rst` is high on a clock edge, `almost_empty_n` is driven low and `almost_full_n` is driven high. Both offset registers take their default value, and both sequencers return to the almost-empty register.
- R2: The default offset depends on `DEPTH`: 31 for a depth of 256 or less, 63 for a depth of 512 or less, and 127 for any larger depth. The default depth is 1024, so the default offset is 127.
- R3: On a `wclk` edge with `ld` and `wr_en` both high, `din[11:0]` is written into the offset register chosen by the load sequencer. `din[17:12]` has no effect on the stored value.
- R4: The sequencers step in the order almost-empty offset, then almost-full offset, then back to almost-empty. The load sequencer moves only on a load access, and the readback sequencer moves only on a readback access.
- R5: On an `rclk` edge with `ld` and `rd_en` both high, the offset chosen by the readback sequencer appears on `rb_data` after that edge. It is zero-extended to 18 bits, and `rb_valid` is high for that one cycle. At all other times `rb_valid` is low.
- R6: `wr_adv` equals `wr_en` and `rd_adv` equals `rd_en`, except while `ld` is high, when both are low.
- R7: `almost_empty_n` is low exactly when `fill_count` is less than or equal to the almost-empty offset. `almost_full_n` is low exactly when `fill_count` plus the almost-full offset is at least `DEPTH`.
- R8: `async_strap` is sampled only while `rst` is high. A value of 0 selects synchronous flags and a value of 1 selects asynchronous flags. Changing the strap outside reset has no effect.
- R9: In synchronous mode, `almost_full_n` reflects the inputs present at the previous `wclk` edge, and `almost_empty_n` reflects the inputs present at the previous `rclk` edge. Neither flag changes between edges.
- R10: In asynchronous mode, both flags follow a change of `fill_count` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, seen by both domains |
| async_strap | input | 1 | Flag mode strap, sampled during reset |
| wr_en | input | 1 | Write enable from the FIFO write port |
| rd_en | input | 1 | Read enable from the FIFO read port |
| ld | input | 1 | Offset access strobe |
| din | input | DATA_W | FIFO data input bus; the low 12 bits carry offset loads |
| fill_count | input | CNT_W | Current FIFO occupancy, from 0 to DEPTH |
| wr_adv | output | 1 | Write pointer advance permitted |
| rd_adv | output | 1 | Read pointer advance permitted |
| rb_data | output | DATA_W | Offset readback value |
| rb_valid | output | 1 | rb_data carries a readback this cycle |
| almost_empty_n | output | 1 | Almost-empty flag, active low |
| almost_full_n | output | 1 | Almost-full flag, active low |

## Verification
The bench tests each compare at the exact boundary and one step away: fill equal to the almost-empty offset and one above it, and fill plus the almost-full offset equal to `DEPTH` and one below it. An off-by-one comparison shows up as a flag that is wrong at exactly one of these points. After loading offsets whose upper data bits are nonzero, it reads both registers back. This exposes a sequencer that does not alternate, a readback that leaks bits 17:12, and a load that overwrites the wrong register. In synchronous mode it samples the flag before and after an edge, so a flag that reacts to the fill level with no edge is caught. In asynchronous mode the bench toggles the strap after reset to catch a mode bit that is not latched. A second reset checks that the loaded offsets go back to their defaults.

// File: rtl/afo_pkg.sv
package afo_pkg;

  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } ofs_sel_e;

  function automatic int dflt_ofs(input int depth);
    if (depth <= 256)      return 31;
    else if (depth <= 512) return 63;
    else                   return 127;
  endfunction

endpackage

// File: rtl/afo_seq.sv
module afo_seq
  import afo_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     step,
  output ofs_sel_e sel
);

  always_ff @(posedge clk) begin
    if (rst)       sel <= SEL_AE;
    else if (step) sel <= (sel == SEL_AE) ? SEL_AF : SEL_AE;
  end

endmodule

// File: rtl/afo_flag.sv
module afo_flag #(
  parameter int DEPTH   = 1024,
  parameter int CNT_W   = 11,
  parameter int OFS_W   = 12,
  parameter bit IS_FULL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             async_strap,
  input  logic [CNT_W-1:0] count,
  input  logic [OFS_W-1:0] ofs,
  output logic             flag_n,
  output logic             mode_async
);

  localparam int  CW      = ((CNT_W > OFS_W) ? CNT_W : OFS_W) + 1;
  localparam logic RST_VAL = IS_FULL;

  logic [CW-1:0] cnt_w;
  logic [CW-1:0] ofs_w;
  logic          hit;
  logic          flag_q;

  assign cnt_w = CW'(count);
  assign ofs_w = CW'(ofs);

  generate
    if (IS_FULL) begin : g_full
      assign hit = (cnt_w + ofs_w) >= CW'(DEPTH);
    end else begin : g_empty
      assign hit = cnt_w <= ofs_w;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_async <= async_strap;
      flag_q     <= RST_VAL;
    end else begin
      flag_q     <= ~hit;
    end
  end

  assign flag_n = mode_async ? (rst ? RST_VAL : ~hit) : flag_q;

endmodule

// File: rtl/almost_flag_unit.sv
module almost_flag_unit
  import afo_pkg::*;
#(
  parameter  int DEPTH  = 1024,
  parameter  int DATA_W = 18,
  parameter  int OFS_W  = 12,
  localparam int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst,
  input  logic              async_strap,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              ld,
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  fill_count,
  output logic              wr_adv,
  output logic              rd_adv,
  output logic [DATA_W-1:0] rb_data,
  output logic              rb_valid,
  output logic              almost_empty_n,
  output logic              almost_full_n
);

  localparam logic [OFS_W-1:0] OFS_RST = OFS_W'(dflt_ofs(DEPTH));

  logic [OFS_W-1:0] ae_ofs;
  logic [OFS_W-1:0] af_ofs;
  logic             load_stb;
  logic             rb_stb;
  ofs_sel_e         wsel;
  ofs_sel_e         rsel;
  logic             ae_mode_async;
  logic             af_mode_async;
  logic             unused_hi;

  assign unused_hi = ^din[DATA_W-1:OFS_W];

  assign load_stb = ld & wr_en;
  assign rb_stb   = ld & rd_en;
  assign wr_adv   = wr_en & ~ld;
  assign rd_adv   = rd_en & ~ld;

  afo_seq u_wseq (.clk(wclk), .rst(rst), .step(load_stb), .sel(wsel));
  afo_seq u_rseq (.clk(rclk), .rst(rst), .step(rb_stb),   .sel(rsel));

  always_ff @(posedge wclk) begin
    if (rst) begin
      ae_ofs <= OFS_RST;
      af_ofs <= OFS_RST;
    end else if (load_stb) begin
      if (wsel == SEL_AE) ae_ofs <= din[OFS_W-1:0];
      else                af_ofs <= din[OFS_W-1:0];
    end
  end

  always_ff @(posedge rclk) begin
    if (rst) begin
      rb_valid <= 1'b0;
      rb_data  <= '0;
    end else begin
      rb_valid <= rb_stb;
      if (rb_stb) rb_data <= DATA_W'((rsel == SEL_AE) ? ae_ofs : af_ofs);
    end
  end

  afo_flag #(.DEPTH(DEPTH), .CNT_W(CNT_W), .OFS_W(OFS_W), .IS_FULL(1'b0)) u_ae (
    .clk(rclk), .rst(rst), .async_strap(async_strap), .count(fill_count),
    .ofs(ae_ofs), .flag_n(almost_empty_n), .mode_async(ae_mode_async)
  );

  afo_flag #(.DEPTH(DEPTH), .CNT_W(CNT_W), .OFS_W(OFS_W), .IS_FULL(1'b1)) u_af (
    .clk(wclk), .rst(rst), .async_strap(async_strap), .count(fill_count),
    .ofs(af_ofs), .flag_n(almost_full_n), .mode_async(af_mode_async)
  );

endmodule

// File: rtl/almost_flag_unit_chk.sv
module almost_flag_unit_chk #(
  parameter int DEPTH = 1024,
  parameter int CNT_W = 11,
  parameter int OFS_W = 12,
  parameter int DATA_W = 18
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              ld,
  input logic [DATA_W-1:0] din,
  input logic [CNT_W-1:0]  fill_count,
  input logic              wr_adv,
  input logic              rd_adv,
  input logic              almost_full_n,
  input logic              almost_empty_n,
  input logic [OFS_W-1:0]  ae_ofs,
  input logic [OFS_W-1:0]  af_ofs,
  input logic              wsel,
  input logic              rsel,
  input logic              af_mode_async,
  input logic              ae_mode_async
);

  // R3
  ae_load_chk: assert property (@(posedge wclk) disable iff (rst)
    (ld && wr_en && !wsel) |=> (ae_ofs == $past(din[OFS_W-1:0])));

  // R4
  wseq_step_chk: assert property (@(posedge wclk) disable iff (rst)
    (ld && wr_en) |=> (wsel != $past(wsel)));

  // R4
  rseq_hold_chk: assert property (@(posedge rclk) disable iff (rst)
    !(ld && rd_en) |=> $stable(rsel));

  // R6
  no_ptr_move_chk: assert property (@(posedge wclk) disable iff (rst)
    ld |-> (!wr_adv && !rd_adv));

  // R9
  sync_full_chk: assert property (@(posedge wclk) disable iff (rst)
    (!af_mode_async && !$past(rst)) |->
      (almost_full_n == ((int'($past(fill_count)) + int'($past(af_ofs))) < DEPTH)));

  // R9
  sync_empty_chk: assert property (@(posedge rclk) disable iff (rst)
    (!ae_mode_async && !$past(rst)) |->
      (almost_empty_n == (int'($past(fill_count)) > int'($past(ae_ofs)))));

endmodule

bind almost_flag_unit almost_flag_unit_chk #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .OFS_W(OFS_W), .DATA_W(DATA_W)
) u_chk (
  .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .ld(ld),
  .din(din), .fill_count(fill_count), .wr_adv(wr_adv), .rd_adv(rd_adv),
  .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n),
  .ae_ofs(ae_ofs), .af_ofs(af_ofs), .wsel(wsel), .rsel(rsel),
  .af_mode_async(af_mode_async), .ae_mode_async(ae_mode_async)
);

// File: tb/almost_flag_unit_test.sv
module almost_flag_unit_test;

  localparam int DEPTH = 1024;
  localparam int DATA_W = 18;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic async_strap = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, ld = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic [CNT_W-1:0]  fill_count = '0;
  logic wr_adv, rd_adv, rb_valid, almost_empty_n, almost_full_n;
  logic [DATA_W-1:0] rb_data;

  int n_checks = 0;
  int n_fail = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  almost_flag_unit #(.DEPTH(DEPTH)) uut (
    .wclk(clk), .rclk(clk), .rst(rst), .async_strap(async_strap),
    .wr_en(wr_en), .rd_en(rd_en), .ld(ld), .din(din), .fill_count(fill_count),
    .wr_adv(wr_adv), .rd_adv(rd_adv), .rb_data(rb_data), .rb_valid(rb_valid),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  // monitor: pops expected readbacks (R5)
  always @(negedge clk) begin
    if (!rst && rb_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected readback", int'(rb_data), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(rb_data == DATA_W'(e), "R5 readback", int'(rb_data), e);
      end
    end
  end

  task automatic do_reset(input bit strap);
    @(negedge clk);
    rst = 1'b1; async_strap = strap; ld = 0; wr_en = 0; rd_en = 0; fill_count = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic readback2(input int e0, input int e1);
    @(negedge clk); ld = 1; rd_en = 1; exp_q.push_back(e0);
    @(negedge clk); exp_q.push_back(e1);
    @(negedge clk); ld = 0; rd_en = 0;
    @(negedge clk);
  endtask

  task automatic load2(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    @(negedge clk); ld = 1; wr_en = 1; din = a;
    #1 check(!wr_adv && !rd_adv, "R6 load blocks pointers", int'(wr_adv), 0);
    @(negedge clk); din = b;
    @(negedge clk); ld = 0; wr_en = 0; din = '0;
  endtask

  task automatic set_fill(input int v);
    @(negedge clk); fill_count = CNT_W'(v);
  endtask

  initial begin
    #(200000 * 8);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    // synchronous mode
    do_reset(1'b0);
    check(almost_empty_n == 1'b0, "R1 reset empty flag", almost_empty_n, 0);
    check(almost_full_n == 1'b1, "R1 reset full flag", almost_full_n, 1);
    // R2 defaults, R4 order AE then AF
    readback2(127, 127);

    // R6 normal enables pass through
    @(negedge clk); wr_en = 1; rd_en = 1;
    #1 check(wr_adv && rd_adv, "R6 pointers move without ld", int'(wr_adv & rd_adv), 1);
    @(negedge clk); wr_en = 0; rd_en = 0;

    // R3 upper bits ignored, R4 second load reaches AF
    load2(18'h3F00A, 18'h2A014);
    readback2(10, 20);
    // R4 readback sequencer wrapped to AE
    readback2(10, 20);

    // R7/R9 almost-empty boundary with ae=10
    set_fill(11);
    #1 check(almost_empty_n == 1'b0, "R9 no change before edge", almost_empty_n, 0);
    @(negedge clk);
    check(almost_empty_n == 1'b1, "R7 fill 11 > ae 10", almost_empty_n, 1);
    set_fill(10);
    @(negedge clk);
    check(almost_empty_n == 1'b0, "R7 fill equals ae", almost_empty_n, 0);

    // almost-full boundary with af=20: low when fill >= 1004
    set_fill(1003);
    @(negedge clk);
    check(almost_full_n == 1'b1, "R7 fill 1003 not almost full", almost_full_n, 1);
    set_fill(1004);
    #1 check(almost_full_n == 1'b1, "R9 full flag waits for wclk", almost_full_n, 1);
    @(negedge clk);
    check(almost_full_n == 1'b0, "R7 fill 1004 almost full", almost_full_n, 0);
    set_fill(1024);
    @(negedge clk);
    check(almost_full_n == 1'b0, "R7 fill at depth", almost_full_n, 0);

    // asynchronous mode; offsets restored to default (R1, R2)
    do_reset(1'b1);
    readback2(127, 127);
    @(negedge clk); async_strap = 1'b0;   // R8: ignored outside reset
    set_fill(128);
    #1 check(almost_empty_n == 1'b1, "R10 async empty release", almost_empty_n, 1);
    set_fill(127);
    #1 check(almost_empty_n == 1'b0, "R10 async empty at offset", almost_empty_n, 0);
    set_fill(897);
    #1 check(almost_full_n == 1'b0, "R10 R8 async full at threshold", almost_full_n, 0);
    set_fill(896);
    #1 check(almost_full_n == 1'b1, "R10 async full below threshold", almost_full_n, 1);

    @(negedge clk);
    check(exp_q.size() == 0, "R5 all readbacks seen", exp_q.size(), 0);
    finish_run();
  end

endmodule